// File: doc/BRIEF.md
# Shadow-Registered Display Timing Generator

This block produces the raster timing for one video output. Two counters step through each line pixel by pixel and through each frame line by line. Decoders then compare the current position against programmed boundaries. The block drives active-high horizontal and vertical sync, a data-enable for the visible area, a layer-enable for a programmable window rectangle inside that area, and a second enable for a separate post-processing window. It also presents the current pixel and line coordinates.

Every boundary is an absolute position counted from the first sync clock of its period. This covers the sync end, the active start and end, the period length, the window start and the post-processing start and end. The window size is written as size minus one. Software writes all fields through a single-cycle write port into a shadow bank. Nothing reaches the raster until a commit write is made. The shadow bank then moves into the working bank as one unit at the next frame boundary, so a frame never mixes old and new settings. Until the first commit the raster is held idle with every output low.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset, and until the first commit has been applied, hsync, vsync, de, layer_en and post_de are low, and pix_x and line_y are 0.
- R2: While running, pix_x counts 0 up to (horizontal total - 1) and then returns to 0. line_y advances by one each time pix_x returns to 0, and returns to 0 after (vertical total - 1).
- R3: hsync is high exactly while pix_x is below the horizontal sync-end value. vsync is high exactly while line_y is below the vertical sync-end value.
- R4: de is high exactly when pix_x is at or above the horizontal active start and below the horizontal active end, and line_y is at or above the vertical active start and below the vertical active end.
- R5: layer_en is high exactly when de is high, bit 0 of the window-enable register is 1, pix_x lies in [x start, x start + width-minus-one], and line_y lies in [y start, y start + height-minus-one], both bounds inclusive.
- R6: post_de is high exactly when pix_x lies in [post h start, post h end) and line_y lies in [post v start, post v end). It does not depend on de.
- R7: Writes to the timing and window registers change nothing at the outputs until a commit is applied, even across frame boundaries.
- R8: A write to the commit address with data bit 0 equal to 1 marks a commit pending. If the raster is idle, the shadow bank is applied on the next clock and the counters start from 0. Otherwise it is applied on the clock where both counters return to 0, and the pending mark then clears.
- R9: A write to the commit address with data bit 0 equal to 0 has no effect.
- R10: Register addresses. Bit 3 of the address selects the axis (0 = horizontal, 1 = vertical) for addresses 0 to 15. Bits 2:0 select the field: 0 total, 1 sync end, 2 active start, 3 active end, 4 window start, 5 window size minus one, 6 post start, 7 post end. Address 16 is the window enable and address 17 is the commit. Totals must be at least 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | AW | Register address (map in R10) |
| wr_data | input | CW | Register write data |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Active-area data enable |
| layer_en | output | 1 | Window rectangle enable inside the active area |
| post_de | output | 1 | Post-processing window enable |
| pix_x | output | CW | Current pixel position in the line |
| line_y | output | CW | Current line position in the frame |

## Verification
The bench programs a series of randomly drawn timings with small porches, so that every frame is short and each edge of each region is crossed many times. Windows are drawn at random, so some fall partly outside the active area or past the end of the line; this separates the layer gating by de from the window compare itself. New settings are written and committed in the middle of a running frame. The outputs must keep the old timing until the boundary and show the new sync width right after it. Timing writes with no commit are run across a whole frame boundary, and commit writes with bit 0 clear are made, so that writes which must stay dormant can be told apart from a premature update.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  // field index inside one axis group (address bits 2:0)
  localparam int F_TOTAL      = 0;
  localparam int F_SYNC_END   = 1;
  localparam int F_ACT_START  = 2;
  localparam int F_ACT_END    = 3;
  localparam int F_WIN_START  = 4;
  localparam int F_WIN_SZM1   = 5;
  localparam int F_POST_START = 6;
  localparam int F_POST_END   = 7;
  localparam int NFLD         = 8;
  localparam int NAXIS        = 2;
  localparam int AXIS_H       = 0;
  localparam int AXIS_V       = 1;
  // flat addresses
  localparam int ADDR_WIN_EN  = NAXIS * NFLD;
  localparam int ADDR_COMMIT  = ADDR_WIN_EN + 1;
  localparam int NREG         = ADDR_WIN_EN + 1;
endpackage

// File: rtl/dtg_axis_cnt.sv
module dtg_axis_cnt #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          step,
  input  logic [CW-1:0] total,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == total - CW'(1));
  assign wrap_o  = run && step && at_last;
  assign cnt_o   = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (step) begin
      if (at_last) cnt_d = '0;
      else         cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dtg_axis_dec.sv
module dtg_axis_dec
  import dtg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic [CW-1:0]            cnt,
  input  logic [NFLD-1:0][CW-1:0]  cfg,
  output logic                     sync_o,
  output logic                     act_o,
  output logic                     win_o,
  output logic                     post_o
);
  localparam int EW = CW + 1;
  logic [EW-1:0] win_last;

  assign win_last = {1'b0, cfg[F_WIN_START]} + {1'b0, cfg[F_WIN_SZM1]};

  always_comb begin
    sync_o = (cnt < cfg[F_SYNC_END]);
    act_o  = (cnt >= cfg[F_ACT_START]) && (cnt < cfg[F_ACT_END]);
    win_o  = (cnt >= cfg[F_WIN_START]) && ({1'b0, cnt} <= win_last);
    post_o = (cnt >= cfg[F_POST_START]) && (cnt < cfg[F_POST_END]);
  end
endmodule

// File: rtl/dtg_regfile.sv
module dtg_regfile
  import dtg_pkg::*;
#(
  parameter int CW = 12,
  parameter int AW = 5
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [AW-1:0]                    wr_addr,
  input  logic [CW-1:0]                    wr_data,
  input  logic                             frame_end,
  output logic                             load_o,
  output logic                             running_o,
  output logic                             pending_o,
  output logic [NAXIS-1:0][NFLD-1:0][CW-1:0] cfg_o,
  output logic                             win_en_o
);
  logic [NREG-1:0][CW-1:0] shadow_q, shadow_d;
  logic [NREG-1:0][CW-1:0] work_q;
  logic pending_q, pending_d;
  logic running_q, running_d;
  logic commit_wr;
  logic load;

  assign commit_wr = wr_en && (wr_addr == AW'(ADDR_COMMIT)) && wr_data[0];
  assign load      = pending_q && (!running_q || frame_end);

  always_comb begin
    shadow_d = shadow_q;
    for (int i = 0; i < NREG; i++) begin
      if (wr_en && (wr_addr == AW'(i))) shadow_d[i] = wr_data;
    end
  end

  always_comb begin
    pending_d = commit_wr || (pending_q && !load);
    running_d = running_q || load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q  <= '0;
      pending_q <= 1'b0;
      running_q <= 1'b0;
    end else begin
      shadow_q  <= shadow_d;
      pending_q <= pending_d;
      running_q <= running_d;
    end
  end

  // working bank: loads only on an applied commit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
    end else if (load) begin
      work_q <= shadow_q;
    end
  end

  for (genvar a = 0; a < NAXIS; a++) begin : g_axis
    for (genvar f = 0; f < NFLD; f++) begin : g_fld
      assign cfg_o[a][f] = work_q[a*NFLD + f];
    end
  end

  assign win_en_o  = work_q[ADDR_WIN_EN][0];
  assign load_o    = load;
  assign running_o = running_q;
  assign pending_o = pending_q;
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
#(
  parameter int CW = 12,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          layer_en,
  output logic          post_de,
  output logic [CW-1:0] pix_x,
  output logic [CW-1:0] line_y
);
  logic [NAXIS-1:0][NFLD-1:0][CW-1:0] cfg;
  logic                               win_en;
  logic                               running;
  logic                               pending;
  logic                               load;
  logic                               frame_end;
  logic [NAXIS-1:0][CW-1:0]           ax_cnt;
  logic [NAXIS-1:0]                   ax_step;
  logic [NAXIS-1:0]                   ax_wrap;
  logic [NAXIS-1:0]                   ax_sync, ax_act, ax_win, ax_post;

  assign frame_end = ax_wrap[AXIS_H] && ax_wrap[AXIS_V];

  dtg_regfile #(.CW(CW), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .frame_end (frame_end),
    .load_o    (load),
    .running_o (running),
    .pending_o (pending),
    .cfg_o     (cfg),
    .win_en_o  (win_en)
  );

  // horizontal steps every clock, vertical on the horizontal wrap
  assign ax_step[AXIS_H] = 1'b1;
  assign ax_step[AXIS_V] = ax_wrap[AXIS_H];

  for (genvar a = 0; a < NAXIS; a++) begin : g_ax
    dtg_axis_cnt #(.CW(CW)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (running),
      .step   (ax_step[a]),
      .total  (cfg[a][F_TOTAL]),
      .cnt_o  (ax_cnt[a]),
      .wrap_o (ax_wrap[a])
    );
    dtg_axis_dec #(.CW(CW)) u_dec (
      .cnt    (ax_cnt[a]),
      .cfg    (cfg[a]),
      .sync_o (ax_sync[a]),
      .act_o  (ax_act[a]),
      .win_o  (ax_win[a]),
      .post_o (ax_post[a])
    );
  end

  always_comb begin
    hsync    = running && ax_sync[AXIS_H];
    vsync    = running && ax_sync[AXIS_V];
    de       = running && (&ax_act);
    layer_en = running && (&ax_act) && win_en && (&ax_win);
    post_de  = running && (&ax_post);
  end

  assign pix_x  = ax_cnt[AXIS_H];
  assign line_y = ax_cnt[AXIS_V];
endmodule

// File: rtl/dtg_chk.sv
module dtg_chk
  import dtg_pkg::*;
#(
  parameter int CW = 12,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [CW-1:0] wr_data,
  input logic          hsync,
  input logic          vsync,
  input logic          de,
  input logic          layer_en,
  input logic          post_de,
  input logic [CW-1:0] pix_x,
  input logic [CW-1:0] line_y,
  input logic          running,
  input logic          pending,
  input logic          load
);
  logic commit_now;
  assign commit_now = wr_en && (wr_addr == AW'(ADDR_COMMIT)) && wr_data[0];

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!hsync && !vsync && !de && !layer_en && !post_de &&
                  pix_x == '0 && line_y == '0));

  // R2
  pix_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_x != '0) |-> (pix_x == $past(pix_x) + CW'(1)));

  // R2
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_x != '0) |-> $stable(line_y));

  // R5
  layer_in_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
    layer_en |-> de);

  // R8
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !commit_now) |=> !pending);

  // R8
  run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);
endmodule

bind disp_timing_gen dtg_chk #(.CW(CW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .hsync    (hsync),
  .vsync    (vsync),
  .de       (de),
  .layer_en (layer_en),
  .post_de  (post_de),
  .pix_x    (pix_x),
  .line_y   (line_y),
  .running  (running),
  .pending  (pending),
  .load     (load)
);

// File: tb/sim_disp_timing_gen.sv
module sim_disp_timing_gen;
  localparam int CW = 12;
  localparam int AW = 5;
  localparam int NR = 17;
  localparam int A_COMMIT = 17;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [CW-1:0] wr_data;
  logic          hsync, vsync, de, layer_en, post_de;
  logic [CW-1:0] pix_x, line_y;

  always #5 clk = ~clk;

  disp_timing_gen #(.CW(CW), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hsync(hsync), .vsync(vsync), .de(de),
    .layer_en(layer_en), .post_de(post_de), .pix_x(pix_x), .line_y(line_y)
  );

  int checks = 0;
  int fails  = 0;
  bit cyc_on = 1'b0;
  bit done   = 1'b0;

  // requirement-level model state
  int sh [NR];
  int wk [NR];
  int cf [NR];
  bit m_pend, m_run;
  int mp, ml;
  int t_ht, t_vt;
  bit t_fe, t_ld, t_cm;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NR; i++) begin sh[i] = 0; wk[i] = 0; end
      m_pend = 0; m_run = 0; mp = 0; ml = 0;
    end else begin
      t_ht = wk[0];
      t_vt = wk[8];
      t_fe = m_run && (mp == t_ht - 1) && (ml == t_vt - 1);
      t_ld = m_pend && (!m_run || t_fe);
      t_cm = wr_en && (int'(wr_addr) == A_COMMIT) && wr_data[0];
      if (!m_run) begin mp = 0; ml = 0; end
      else if (mp == t_ht - 1) begin mp = 0; ml = (ml == t_vt - 1) ? 0 : ml + 1; end
      else mp = mp + 1;
      if (t_ld) begin
        for (int i = 0; i < NR; i++) wk[i] = sh[i];
        m_run = 1;
      end
      m_pend = t_cm || (m_pend && !t_ld);
      if (wr_en && int'(wr_addr) < NR) sh[int'(wr_addr)] = int'(wr_data);
    end
  end

  function automatic int e_hs(); return int'(m_run && mp < wk[1]); endfunction
  function automatic int e_vs(); return int'(m_run && ml < wk[9]); endfunction
  function automatic int e_de();
    return int'(m_run && mp >= wk[2] && mp < wk[3] && ml >= wk[10] && ml < wk[11]);
  endfunction
  function automatic int e_ly();
    return int'(e_de() == 1 && wk[16] % 2 == 1 && mp >= wk[4] && mp <= wk[4] + wk[5]
                && ml >= wk[12] && ml <= wk[12] + wk[13]);
  endfunction
  function automatic int e_po();
    return int'(m_run && mp >= wk[6] && mp < wk[7] && ml >= wk[14] && ml < wk[15]);
  endfunction

  always @(negedge clk) begin
    if (cyc_on && rst_n) begin
      chk("R2", "pix_x",    int'(pix_x),    mp);
      chk("R2", "line_y",   int'(line_y),   ml);
      chk("R3", "hsync",    int'(hsync),    e_hs());
      chk("R3", "vsync",    int'(vsync),    e_vs());
      chk("R4", "de",       int'(de),       e_de());
      chk("R5", "layer_en", int'(layer_en), e_ly());
      chk("R6", "post_de",  int'(post_de),  e_po());
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = CW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic program_cfg();
    for (int i = 0; i < NR; i++) wr(i, cf[i]);
  endtask

  task automatic gen_axis(input int b, input int smax, input int amin, input int arng);
    int s, bp, act, fp, tot;
    s   = 1 + int'($urandom % 32'(smax));
    bp  = 1 + int'($urandom % 32'd3);
    act = amin + int'($urandom % 32'(arng));
    fp  = 1 + int'($urandom % 32'd3);
    tot = s + bp + act + fp;
    cf[b+0] = tot;
    cf[b+1] = s;
    cf[b+2] = s + bp;
    cf[b+3] = s + bp + act;
    cf[b+4] = s + bp + int'($urandom % 32'(act));
    cf[b+5] = int'($urandom % 32'(act + 2));
    cf[b+6] = int'($urandom % 32'(tot));
    cf[b+7] = cf[b+6] + int'($urandom % 32'(tot - cf[b+6] + 1));
  endtask

  task automatic gen_cfg();
    gen_axis(0, 3, 4, 7);
    gen_axis(8, 2, 2, 4);
    cf[16] = int'($urandom % 32'd2);
  endtask

  task automatic run_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // commit, then confirm the new sync width right after the boundary (R8)
  task automatic commit_and_check();
    int lim;
    wr(A_COMMIT, 1);
    lim = 0;
    @(negedge clk);
    while (!(pix_x == '0 && line_y == '0) && lim < 1000) begin
      @(negedge clk); lim++;
    end
    chk("R8", "hsync at boundary", int'(hsync), 1);
    repeat (cf[1] - 1) @(negedge clk);
    chk("R8", "hsync last sync pixel", int'(hsync), 1);
    @(negedge clk);
    chk("R8", "hsync after new sync end", int'(hsync), 0);
  endtask

  initial begin
    int f0;
    void'($urandom(32'd4242));
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk("R1", "hsync in reset", int'(hsync), 0);
    chk("R1", "de in reset", int'(de), 0);
    rst_n = 1'b1;
    cyc_on = 1'b1;

    // R7 / R10: program without commit, outputs stay idle
    gen_cfg();
    program_cfg();
    run_cycles(40);
    chk("R7", "pix_x idle without commit", int'(pix_x), 0);
    chk("R1", "vsync idle before commit", int'(vsync), 0);

    // R9: commit with bit 0 clear
    wr(A_COMMIT, 2);
    run_cycles(10);
    chk("R9", "hsync after void commit", int'(hsync), 0);
    chk("R9", "pix_x after void commit", int'(pix_x), 0);

    // R8: first commit applies on the next clock
    wr(A_COMMIT, 1);
    @(negedge clk);
    chk("R8", "first commit hsync", int'(hsync), 1);
    chk("R8", "first commit pix_x", int'(pix_x), 0);
    run_cycles(2 * cf[0] * cf[8]);

    for (int k = 0; k < 8; k++) begin
      int old_len;
      old_len = wk[0] * wk[8];
      gen_cfg();
      if (k == 5) begin   // single-pixel window, enabled
        cf[5] = 0; cf[13] = 0; cf[16] = 1;
      end
      if (k == 6) begin   // window covers everything but disabled
        cf[4] = 0; cf[5] = 200; cf[12] = 0; cf[13] = 200; cf[16] = 0;
      end
      if (k == 7) begin   // window enabled, reaches past line end
        cf[5] = 200; cf[13] = 200; cf[16] = 1;
      end
      f0 = fails;
      program_cfg();
      run_cycles(old_len + 3);
      chk("R7", "failures while uncommitted", fails - f0, 0);
      commit_and_check();
      run_cycles(2 * cf[0] * cf[8]);
    end

    cyc_on = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule